// File: doc/BRIEF.md
# Byte-Lane Late-Write Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous static RAM. A small parameterised array stands in for a large memory core. All commands are sampled on the rising clock edge. An active-low select and an active-low global write enable choose between no-operation, read and write. Four active-low byte enables pick which 9-bit lanes a write updates.

A write is split over two clock edges. The edge that sees the write command captures its address and lane mask. The following edge samples the write data and updates the array. Because of this, read and write addresses live in separate registers. A read issued directly after a write to the same address is served by forwarding the lanes being written that cycle.

Read data comes from a registered output stage and is valid after the read command's edge. An asynchronous output enable masks the lane drivers only. An asynchronous power-down input masks the drivers and also blocks new commands.

Top module: `lateWriteSram`

## Requirements
- R1: While reset is low and right after it, all drive enables are low. A write whose command edge came before reset is never committed to the array.
- R2: With power-down low, select low and write enable high, the edge starts a read. After that edge all four `dOe` bits are high (when `outEnN` and `sleep` are low) and `dOut` holds the addressed word. The lanes of `dOut` are ordered lane 0 = bits 8:0 through lane 3 = bits 35:27.
- R3: With select low and write enable low, each lane i whose `byteWrN[i]` is low is written. Lanes whose enable is high keep their old contents.
- R4: A write command with all four byte enables high changes no lane of the addressed word.
- R5: Write data is taken from `dIn` on the edge after the write command. The value on `dIn` at the command edge is ignored.
- R6: A read issued on the edge right after a write command to the same address returns the new data for the written lanes and the old data for the others.
- R7: With select high, the cycle does nothing: no write happens, whatever `wrN` and `byteWrN` are, and `dOe` is low after the edge.
- R8: `outEnN` high forces every `dOe` bit low at once. Reads and writes are still accepted while it is high.
- R9: `sleep` high forces every `dOe` bit low at once. A read or write command on an edge where `sleep` is high is ignored.
- R10: Write commands on consecutive edges each commit, taking their data on the edge after their own command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of the control flags |
| selN | input | 1 | Synchronous select, active low |
| wrN | input | 1 | Synchronous global write enable, active low |
| byteWrN | input | LANES | Per-lane write enable, active low, bit i = lane i |
| outEnN | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous power-down, active high |
| addr | input | ADDR_W | Word address for read and write commands |
| dIn | input | LANES*LANE_W | Write data, sampled one edge after the write command |
| dOut | output | LANES*LANE_W | Registered read data |
| dOe | output | LANES | Per-lane drive enable for `dOut` |

## Verification
A commit of a pending write and a new read can land on the same edge. The hard case is a read of the address being committed, because the array has not taken the new bytes yet. The bench provokes this by placing a partial-lane write command directly before a read of the same word, with fresh data on `dIn` during the read cycle. It then compares each lane of `dOut`: enabled lanes must show the fresh data, disabled lanes the older stored bytes. A second collision is two write commands on back-to-back edges, where one edge both commits the first write and captures the second command. Later reads of both words judge this case.

// File: rtl/lwsPkg.sv
package lwsPkg;

  // Strobes from the control unit to the datapath, valid in the current cycle
  typedef struct packed {
    logic issueRead;   // this edge captures a read command
    logic issueWrite;  // this edge captures a write command (address and mask)
    logic commit;      // this edge samples write data and updates the array
  } lwsStrobes_t;

endpackage

// File: rtl/lwsCtrl.sv
module lwsCtrl
  import lwsPkg::*;
#(
  parameter int LANES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selN,
  input  logic              wrN,
  input  logic              outEnN,
  input  logic              sleep,
  output lwsStrobes_t       stb,
  output logic [LANES-1:0]  dOe
);

  logic pendWr;
  logic rdValid;
  logic active;

  // Commands are accepted only when selected and not powered down
  always_comb begin
    active         = !sleep && !selN;
    stb.issueRead  = active && wrN;
    stb.issueWrite = active && !wrN;
    stb.commit     = pendWr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendWr  <= 1'b0;
      rdValid <= 1'b0;
    end else begin
      pendWr  <= stb.issueWrite;
      rdValid <= stb.issueRead;
    end
  end

  // Drivers follow the asynchronous masks without waiting for a clock
  assign dOe = {LANES{rdValid && !outEnN && !sleep}};

endmodule

// File: rtl/lwsDatapath.sv
module lwsDatapath
  import lwsPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  lwsStrobes_t               stb,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES-1:0]          byteWrN,
  input  logic [LANES*LANE_W-1:0]   dIn,
  output logic [LANES*LANE_W-1:0]   dOut
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] wrAddr;
  logic [LANES-1:0]  wrMask;
  logic              fwdHit;

  // Write-address register: holds the command until its data phase
  always_ff @(posedge clk) begin
    if (stb.issueWrite) begin
      wrAddr <= addr;
      wrMask <= ~byteWrN;
    end
  end

  // Read on the commit edge of the same word needs the in-flight data
  assign fwdHit = stb.commit && (wrAddr == addr);

  for (genvar l = 0; l < LANES; l++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    logic [LANE_W-1:0] laneIn;
    logic [LANE_W-1:0] laneQ;

    assign laneIn = dIn[l*LANE_W +: LANE_W];

    always_ff @(posedge clk) begin
      if (stb.commit && wrMask[l]) begin
        laneMem[wrAddr] <= laneIn;
      end
      if (stb.issueRead) begin
        laneQ <= (fwdHit && wrMask[l]) ? laneIn : laneMem[addr];
      end
    end

    assign dOut[l*LANE_W +: LANE_W] = laneQ;
  end

endmodule

// File: rtl/lateWriteSram.sv
module lateWriteSram
  import lwsPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     selN,
  input  logic                     wrN,
  input  logic [LANES-1:0]         byteWrN,
  input  logic                     outEnN,
  input  logic                     sleep,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [LANES*LANE_W-1:0]  dIn,
  output logic [LANES*LANE_W-1:0]  dOut,
  output logic [LANES-1:0]         dOe
);

  lwsStrobes_t strobes;

  lwsCtrl #(.LANES(LANES)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .selN   (selN),
    .wrN    (wrN),
    .outEnN (outEnN),
    .sleep  (sleep),
    .stb    (strobes),
    .dOe    (dOe)
  );

  lwsDatapath #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) dp_i (
    .clk     (clk),
    .stb     (strobes),
    .addr    (addr),
    .byteWrN (byteWrN),
    .dIn     (dIn),
    .dOut    (dOut)
  );

endmodule

// File: rtl/lwsChecker.sv
module lwsChecker #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             selN,
  input logic             wrN,
  input logic             outEnN,
  input logic             sleep,
  input logic [LANES-1:0] dOe,
  input logic             commitStb
);

  // R2
  read_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && !selN && wrN) |=> (dOe == {LANES{!outEnN && !sleep}}));

  // R2
  lanes_agree_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dOe == '0) || (dOe == '1));

  // R7
  nop_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (selN || sleep) |=> (dOe == '0));

  // R8
  oe_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> (dOe == '0));

  // R9
  sleep_hiz_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> (dOe == '0));

  // R5
  commit_after_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitStb |-> $past(!sleep && !selN && !wrN));

endmodule

bind lateWriteSram lwsChecker #(.LANES(LANES)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .selN      (selN),
  .wrN       (wrN),
  .outEnN    (outEnN),
  .sleep     (sleep),
  .dOe       (dOe),
  .commitStb (strobes.commit)
);

// File: tb/lateWriteSram_tb_top.sv
module lateWriteSram_tb_top;

  localparam int ADDR_W = 6;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int DW     = LANES * LANE_W;

  localparam logic [1:0] NOP = 2'd0, RD = 2'd1, WR = 2'd2, SW = 2'd3;

  typedef struct packed {
    logic [1:0]        kind;
    logic [ADDR_W-1:0] a;
    logic [LANES-1:0]  bwN;
    logic              oeN;
    logic              slp;
    logic [DW-1:0]     din;
    logic [LANES-1:0]  eOe;
    logic [DW-1:0]     eQ;
  } vec_t;

  function automatic logic [DW-1:0] w(input logic [8:0] l3, l2, l1, l0);
    return {l3, l2, l1, l0};
  endfunction

  function automatic vec_t mk(input logic [1:0] k, input logic [ADDR_W-1:0] a,
      input logic [LANES-1:0] bwN, input logic oeN, input logic slp,
      input logic [DW-1:0] din, input logic [LANES-1:0] eOe, input logic [DW-1:0] eQ);
    vec_t v;
    v.kind = k; v.a = a; v.bwN = bwN; v.oeN = oeN; v.slp = slp;
    v.din = din; v.eOe = eOe; v.eQ = eQ;
    return v;
  endfunction

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    mk(WR, 6'd1, 4'h0, 0, 0, w(9'h1FF, 9'h1FF, 9'h1FF, 9'h1FF), 4'h0, '0),
    mk(NOP, 6'd0, 4'hF, 0, 0, w(9'h011, 9'h022, 9'h033, 9'h044), 4'h0, '0),
    mk(RD, 6'd1, 4'hF, 0, 0, '0, 4'hF, w(9'h011, 9'h022, 9'h033, 9'h044)),
    mk(WR, 6'd1, 4'b1010, 0, 0, '0, 4'h0, '0),
    mk(RD, 6'd1, 4'hF, 0, 0, w(9'h1AA, 9'h1BB, 9'h1CC, 9'h1DD), 4'hF, w(9'h011, 9'h1BB, 9'h033, 9'h1DD)),
    mk(WR, 6'd2, 4'h0, 0, 0, '0, 4'h0, '0),
    mk(NOP, 6'd0, 4'hF, 0, 0, w(9'h0A0, 9'h0A1, 9'h0A2, 9'h0A3), 4'h0, '0),
    mk(WR, 6'd2, 4'hF, 0, 0, '0, 4'h0, '0),
    mk(NOP, 6'd0, 4'hF, 0, 0, w(9'h155, 9'h155, 9'h155, 9'h155), 4'h0, '0),
    mk(RD, 6'd2, 4'hF, 0, 0, '0, 4'hF, w(9'h0A0, 9'h0A1, 9'h0A2, 9'h0A3)),
    mk(WR, 6'd3, 4'h0, 0, 0, '0, 4'h0, '0),
    mk(WR, 6'd4, 4'h0, 0, 0, w(9'h003, 9'h003, 9'h003, 9'h003), 4'h0, '0),
    mk(RD, 6'd3, 4'hF, 0, 0, w(9'h004, 9'h004, 9'h004, 9'h004), 4'hF, w(9'h003, 9'h003, 9'h003, 9'h003)),
    mk(RD, 6'd4, 4'hF, 0, 0, '0, 4'hF, w(9'h004, 9'h004, 9'h004, 9'h004)),
    mk(RD, 6'd1, 4'hF, 1, 0, '0, 4'h0, '0),
    mk(NOP, 6'd0, 4'hF, 0, 0, '0, 4'h0, '0),
    mk(SW, 6'd1, 4'h0, 0, 0, '0, 4'h0, '0),
    mk(NOP, 6'd0, 4'hF, 0, 0, w(9'h1EE, 9'h1EE, 9'h1EE, 9'h1EE), 4'h0, '0),
    mk(RD, 6'd1, 4'hF, 0, 0, '0, 4'hF, w(9'h011, 9'h1BB, 9'h033, 9'h1DD)),
    mk(WR, 6'd1, 4'h0, 1, 0, '0, 4'h0, '0),
    mk(NOP, 6'd0, 4'hF, 1, 0, w(9'h066, 9'h077, 9'h088, 9'h099), 4'h0, '0),
    mk(RD, 6'd1, 4'hF, 0, 0, '0, 4'hF, w(9'h066, 9'h077, 9'h088, 9'h099)),
    mk(WR, 6'd1, 4'h0, 0, 1, '0, 4'h0, '0),
    mk(NOP, 6'd0, 4'hF, 0, 0, w(9'h1FF, 9'h1FF, 9'h1FF, 9'h1FF), 4'h0, '0),
    mk(RD, 6'd1, 4'hF, 0, 1, '0, 4'h0, '0),
    mk(RD, 6'd1, 4'hF, 0, 0, '0, 4'hF, w(9'h066, 9'h077, 9'h088, 9'h099))
  };

  // Requirement tag per vector, for messages
  localparam string TAGS [NV] = '{
    "R5", "R5", "R2", "R3", "R6", "R3", "R3", "R4", "R4", "R4",
    "R10", "R10", "R10", "R10", "R8", "R7", "R7", "R7", "R7",
    "R8", "R8", "R8", "R9", "R9", "R9", "R9"
  };

  logic              clk = 1'b0;
  logic              rstN;
  logic              selN, wrN, outEnN, sleep;
  logic [LANES-1:0]  byteWrN;
  logic [ADDR_W-1:0] addr;
  logic [DW-1:0]     dIn, dOut;
  logic [LANES-1:0]  dOe;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  lateWriteSram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) dut_i (
    .clk(clk), .rstN(rstN), .selN(selN), .wrN(wrN), .byteWrN(byteWrN),
    .outEnN(outEnN), .sleep(sleep), .addr(addr), .dIn(dIn),
    .dOut(dOut), .dOe(dOe)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] k, input logic [ADDR_W-1:0] a,
      input logic [LANES-1:0] bwN, input logic oeN, input logic slp, input logic [DW-1:0] din);
    selN    = (k == NOP) || (k == SW);
    wrN     = !((k == WR) || (k == SW));
    addr    = a;
    byteWrN = bwN;
    outEnN  = oeN;
    sleep   = slp;
    dIn     = din;
  endtask

  initial begin
    rstN = 1'b0;
    drive(NOP, '0, '1, 1'b0, 1'b0, '0);
    repeat (3) @(negedge clk);
    check("R1", DW'(dOe), '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", DW'(dOe), '0);

    // Table walk: apply at a falling edge, judge after the next rising edge
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].kind, VECS[i].a, VECS[i].bwN, VECS[i].oeN, VECS[i].slp, VECS[i].din);
      @(negedge clk);
      check(TAGS[i], DW'(dOe), DW'(VECS[i].eOe));
      if (VECS[i].eOe != '0) check(TAGS[i], dOut, VECS[i].eQ);
    end

    // R8 / R9: drivers react to the asynchronous masks without a clock
    drive(RD, 6'd1, '1, 1'b0, 1'b0, '0);
    @(negedge clk);
    drive(NOP, '0, '1, 1'b0, 1'b0, '0);
    check("R2", DW'(dOe), DW'(4'hF));
    outEnN = 1'b1; #1;
    check("R8", DW'(dOe), '0);
    outEnN = 1'b0; #1;
    check("R8", DW'(dOe), DW'(4'hF));
    sleep = 1'b1; #1;
    check("R9", DW'(dOe), '0);
    sleep = 1'b0;
    @(negedge clk);

    // R1: a write command cut off by reset before its data phase
    drive(WR, 6'd5, '0, 1'b0, 1'b0, '0);
    @(negedge clk);
    drive(NOP, '0, '1, 1'b0, 1'b0, w(9'h005, 9'h005, 9'h005, 9'h005));
    @(negedge clk);
    drive(WR, 6'd5, '0, 1'b0, 1'b0, '0);
    @(negedge clk);
    drive(NOP, '0, '1, 1'b0, 1'b0, w(9'h1FF, 9'h1FF, 9'h1FF, 9'h1FF));
    rstN = 1'b0; #1;
    check("R1", DW'(dOe), '0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", DW'(dOe), '0);
    drive(RD, 6'd5, '1, 1'b0, 1'b0, '0);
    @(negedge clk);
    check("R1", DW'(dOe), DW'(4'hF));
    check("R1", dOut, w(9'h005, 9'h005, 9'h005, 9'h005));
    drive(NOP, '0, '1, 1'b0, 1'b0, '0);
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule